// File: doc/BRIEF.md
# Modified Dual-Slope Converter Sequencer

This block is the digital half of a charge-balancing integrating voltmeter. A free-running frame of 4000 counting ticks (10 kHz ticks give 2.5 conversions per second) is kept by a three-decade BCD counter followed by a divide-by-four stage. At every frame boundary the block switches the reference current into the integrator, so the integrator ramps downward. When the integrator crosses 0 V, the comparator reports it and the block switches the reference off again. For the rest of the frame only the input current is integrated. The number of ticks between the frame start and the crossing is the reading, at 1000 counts per volt.

The crossing time is caught in a holding register. The visible reading is updated only at the frame boundary, so a partial count is never shown. A crossing in the first quarter of the frame gives a leading digit of 0, and one in the second quarter gives a leading "1". A crossing in the second half of the frame, or no crossing at all, is out of range. It raises an overrange flag and leaves the old digits on show. The outputs are the three BCD digits, the leading digit, a sign bit and the overrange flag, which feed a seven-segment driver. The analog integrator, comparator, rectifier and reference source are outside this block.

Top module: `dual_slope_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the frame count and the reading (`bcd_o`=0, `lead_o`=0, `sign_o`=0, `over_o`=0) and sets `ref_en_o` to 1.
- R2: The frame count advances only on clock edges with `tick_i`=1. A frame is exactly 4000 such ticks: after a crossing, `ref_en_o` stays 0 through tick 3999 of the frame.
- R3: At the edge that carries the 4000th tick of a frame, `ref_en_o` becomes 1 and the count restarts at 0.
- R4: `cmp_below_i` (1 = integrator below 0 V) passes through a two-flop synchronizer and a rising-edge detector. While `ref_en_o`=1, a rise of the input clears `ref_en_o` at the third clock edge after it. That same edge captures the count, which is the number of ticks since the frame start.
- R5: Only the first accepted rise in a frame is used. Later rises in the same frame neither re-enable the reference nor change the reading.
- R6: `bcd_o`, `lead_o`, `sign_o` and `over_o` change only at the frame-end edge.
- R7: A captured count K below 1000 shows `lead_o`=0 and `bcd_o` = BCD of K. A count K from 1000 to 1999 shows `lead_o`=1 and `bcd_o` = BCD of K-1000. In `bcd_o`, hundreds sit in [11:8], tens in [7:4] and units in [3:0].
- R8: `sign_o` shows `pol_neg_i` as sampled at the capture edge. Later changes of `pol_neg_i` in that frame have no effect.
- R9: If a frame has no accepted crossing, or the captured count is 2000 or more, the frame end sets `over_o`=1 and leaves `bcd_o`, `lead_o` and `sign_o` unchanged.
- R10: If a crossing is accepted on the same edge as the frame end, the capture belongs to the closing frame (count 3999, so it is out of range) and `ref_en_o` is 1 for the new frame.
- R11: The first frame end after a valid capture clears `over_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Counting-tick enable (10 kHz rate) |
| cmp_below_i | input | 1 | Asynchronous comparator output, 1 when the integrator is below 0 V |
| pol_neg_i | input | 1 | Input polarity from the rectifier stage, 1 = negative |
| ref_en_o | output | 1 | Enable for the reference current source |
| bcd_o | output | 12 | Latched BCD digits: hundreds, tens, units |
| lead_o | output | 1 | Latched leading digit (0 or 1) |
| sign_o | output | 1 | Latched sign, 1 = negative |
| over_o | output | 1 | Overrange / invalid-reading flag |

## Verification
The crossing capture and the frame-end commit can fall on the same clock edge. In that case the block must decide which frame the capture belongs to, and whether the reference comes back on. The bench provokes this by stopping the ticks at count 3999, raising the comparator, and releasing the final tick exactly on the edge where the synchronized rise is taken. It then checks three things: the overrange flag is set, the old digits are held, and `ref_en_o` is 1. The next frame must also read normally, with no stray capture carried over from the shared edge.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef logic [3:0] bcd_t;

   localparam bcd_t BCD_TOP = 4'd9;

   function automatic bcd_t bcd_step(input bcd_t d);
      return (d == BCD_TOP) ? 4'd0 : d + 4'd1;
   endfunction

endpackage

// File: rtl/dsc_cmp_sync.sv
module dsc_cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dsc_cmp_sync: STAGES must be at least 2");
   end

   // STAGES synchronizer flops plus one edge-detect flop
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-1:0], async_i};
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise_o |=> !rise_o); // R5

endmodule

// File: rtl/dsc_frame_count.sv
module dsc_frame_count
   import dsc_pkg::*;
#(
   parameter int DIGITS = 3,
   parameter int SPANS  = 4,
   localparam int SPAN_W = (SPANS > 2) ? $clog2(SPANS) : 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  tick_i,
   output logic [4*DIGITS-1:0]   digits_o,
   output logic [SPAN_W-1:0]     span_o,
   output logic                  frame_end_o
);

   if (DIGITS < 1) begin : g_bad_digits
      $error("dsc_frame_count: DIGITS must be at least 1");
   end
   if (SPANS < 2) begin : g_bad_spans
      $error("dsc_frame_count: SPANS must be at least 2");
   end

   localparam logic [SPAN_W-1:0] SPAN_LAST = SPAN_W'(SPANS - 1);

   logic [DIGITS:0]   carry;
   logic [SPAN_W-1:0] span_q;

   assign carry[0] = tick_i;

   for (genvar gi = 0; gi < DIGITS; gi++) begin : g_decade
      bcd_t dig_q;

      always_ff @(posedge clk) begin
         if (rst)            dig_q <= '0;
         else if (carry[gi]) dig_q <= bcd_step(dig_q);
      end

      assign carry[gi+1]          = carry[gi] & (dig_q == BCD_TOP);
      assign digits_o[gi*4 +: 4]  = dig_q;

      AST_DIGIT_BCD: assert property (@(posedge clk) disable iff (rst)
         dig_q <= BCD_TOP); // R7
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         span_q <= '0;
      end else if (carry[DIGITS]) begin
         span_q <= (span_q == SPAN_LAST) ? '0 : span_q + 1'b1;
      end
   end

   assign span_o      = span_q;
   assign frame_end_o = carry[DIGITS] & (span_q == SPAN_LAST);

   AST_SPAN_RANGE: assert property (@(posedge clk) disable iff (rst)
      span_q <= SPAN_LAST); // R2

   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
      frame_end_o |=> (span_o == '0 && digits_o == '0)); // R3

endmodule

// File: rtl/dsc_slope_ctrl.sv
module dsc_slope_ctrl #(
   parameter int DIGITS   = 3,
   parameter int SPAN_W   = 2,
   parameter int LEAD_MAX = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                frame_end_i,
   input  logic                rise_i,
   input  logic [4*DIGITS-1:0] digits_i,
   input  logic [SPAN_W-1:0]   span_i,
   input  logic                pol_i,
   output logic                ref_en_o,
   output logic                commit_o,
   output logic                close_valid_o,
   output logic [4*DIGITS-1:0] close_digits_o,
   output logic [SPAN_W-1:0]   close_span_o,
   output logic                close_pol_o
);

   localparam logic [SPAN_W-1:0] SPAN_OK = SPAN_W'(LEAD_MAX);

   logic                ref_q;
   logic [4*DIGITS-1:0] cap_dig_q;
   logic [SPAN_W-1:0]   cap_span_q;
   logic                cap_pol_q;
   logic                accept;
   logic                have_cap;

   // a crossing only counts while the reference is still on in this frame
   assign accept   = rise_i & ref_q;
   assign have_cap = ~ref_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_q <= 1'b1;
      end else if (frame_end_i) begin
         ref_q <= 1'b1;
      end else if (accept) begin
         ref_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_dig_q  <= '0;
         cap_span_q <= '0;
         cap_pol_q  <= 1'b0;
      end else if (accept) begin
         cap_dig_q  <= digits_i;
         cap_span_q <= span_i;
         cap_pol_q  <= pol_i;
      end
   end

   // a capture on the frame-end edge itself belongs to the closing frame
   always_comb begin
      if (accept) begin
         close_digits_o = digits_i;
         close_span_o   = span_i;
         close_pol_o    = pol_i;
      end else begin
         close_digits_o = cap_dig_q;
         close_span_o   = cap_span_q;
         close_pol_o    = cap_pol_q;
      end
      close_valid_o = (accept | have_cap) & (close_span_o <= SPAN_OK);
   end

   assign ref_en_o = ref_q;
   assign commit_o = frame_end_i;

   AST_REF_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
      frame_end_i |=> ref_q); // R3

   AST_REF_DROP: assert property (@(posedge clk) disable iff (rst)
      (accept && !frame_end_i) |=> !ref_q); // R4

   AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (!ref_q && !frame_end_i) |=> (!ref_q && $stable(cap_dig_q) && $stable(cap_pol_q))); // R5

   AST_COINCIDE: assert property (@(posedge clk) disable iff (rst)
      (accept && frame_end_i) |=> ref_q); // R10

endmodule

// File: rtl/dsc_readout.sv
module dsc_readout #(
   parameter int DIGITS = 3,
   parameter int SPAN_W = 2,
   parameter int LEAD_W = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                commit_i,
   input  logic                valid_i,
   input  logic [4*DIGITS-1:0] digits_i,
   input  logic [SPAN_W-1:0]   span_i,
   input  logic                pol_i,
   output logic [4*DIGITS-1:0] bcd_o,
   output logic [LEAD_W-1:0]   lead_o,
   output logic                sign_o,
   output logic                over_o
);

   if (LEAD_W > SPAN_W) begin : g_bad_lead
      $error("dsc_readout: LEAD_W must not exceed SPAN_W");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bcd_o  <= '0;
         lead_o <= '0;
         sign_o <= 1'b0;
         over_o <= 1'b0;
      end else if (commit_i) begin
         if (valid_i) begin
            bcd_o  <= digits_i;
            lead_o <= span_i[LEAD_W-1:0];
            sign_o <= pol_i;
            over_o <= 1'b0;
         end else begin
            over_o <= 1'b1;
         end
      end
   end

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
      !commit_i |=> ($stable(bcd_o) && $stable(lead_o) && $stable(sign_o) && $stable(over_o))); // R6

   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (commit_i && !valid_i) |=> (over_o && $stable(bcd_o) && $stable(lead_o) && $stable(sign_o))); // R9

   AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (commit_i && valid_i) |=> !over_o); // R11

endmodule

// File: rtl/dual_slope_ctl.sv
module dual_slope_ctl #(
   parameter int DIGITS      = 3,
   parameter int SPANS       = 4,
   parameter int LEAD_MAX    = 1,
   parameter int SYNC_STAGES = 2,
   localparam int SPAN_W = (SPANS > 2) ? $clog2(SPANS) : 1,
   localparam int LEAD_W = (LEAD_MAX < 2) ? 1 : $clog2(LEAD_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                tick_i,
   input  logic                cmp_below_i,
   input  logic                pol_neg_i,
   output logic                ref_en_o,
   output logic [4*DIGITS-1:0] bcd_o,
   output logic [LEAD_W-1:0]   lead_o,
   output logic                sign_o,
   output logic                over_o
);

   if (LEAD_MAX < 1 || LEAD_MAX >= SPANS) begin : g_bad_lead
      $error("dual_slope_ctl: LEAD_MAX must lie in 1..SPANS-1");
   end

   logic [4*DIGITS-1:0] cnt_digits;
   logic [SPAN_W-1:0]   cnt_span;
   logic                frame_end;
   logic                cmp_rise;
   logic                commit;
   logic                close_valid;
   logic [4*DIGITS-1:0] close_digits;
   logic [SPAN_W-1:0]   close_span;
   logic                close_pol;

   dsc_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (cmp_below_i),
      .rise_o  (cmp_rise)
   );

   dsc_frame_count #(.DIGITS(DIGITS), .SPANS(SPANS)) u_count (
      .clk         (clk),
      .rst         (rst),
      .tick_i      (tick_i),
      .digits_o    (cnt_digits),
      .span_o      (cnt_span),
      .frame_end_o (frame_end)
   );

   dsc_slope_ctrl #(.DIGITS(DIGITS), .SPAN_W(SPAN_W), .LEAD_MAX(LEAD_MAX)) u_ctrl (
      .clk            (clk),
      .rst            (rst),
      .frame_end_i    (frame_end),
      .rise_i         (cmp_rise),
      .digits_i       (cnt_digits),
      .span_i         (cnt_span),
      .pol_i          (pol_neg_i),
      .ref_en_o       (ref_en_o),
      .commit_o       (commit),
      .close_valid_o  (close_valid),
      .close_digits_o (close_digits),
      .close_span_o   (close_span),
      .close_pol_o    (close_pol)
   );

   dsc_readout #(.DIGITS(DIGITS), .SPAN_W(SPAN_W), .LEAD_W(LEAD_W)) u_readout (
      .clk      (clk),
      .rst      (rst),
      .commit_i (commit),
      .valid_i  (close_valid),
      .digits_i (close_digits),
      .span_i   (close_span),
      .pol_i    (close_pol),
      .bcd_o    (bcd_o),
      .lead_o   (lead_o),
      .sign_o   (sign_o),
      .over_o   (over_o)
   );

   AST_REF_STEADY: assert property (@(posedge clk) disable iff (rst)
      (!ref_en_o && !frame_end) |=> !ref_en_o); // R2

endmodule

// File: tb/dual_slope_ctl_bench.sv
`timescale 1ns/1ps
module dual_slope_ctl_bench;

   localparam int FRAME = 4000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_i = 1'b0;
   logic        cmp_below_i = 1'b0;
   logic        pol_neg_i = 1'b0;
   logic        ref_en_o;
   logic [11:0] bcd_o;
   logic [0:0]  lead_o;
   logic        sign_o;
   logic        over_o;

   int errs = 0;
   int checks = 0;
   bit use_gaps = 1'b0;

   logic [11:0] e_bcd = '0;
   logic        e_lead = 1'b0;
   logic        e_sign = 1'b0;
   logic        e_over = 1'b0;

   always #4 clk = ~clk;

   dual_slope_ctl u_dual_slope_ctl (
      .clk         (clk),
      .rst         (rst),
      .tick_i      (tick_i),
      .cmp_below_i (cmp_below_i),
      .pol_neg_i   (pol_neg_i),
      .ref_en_o    (ref_en_o),
      .bcd_o       (bcd_o),
      .lead_o      (lead_o),
      .sign_o      (sign_o),
      .over_o      (over_o)
   );

   function automatic logic [11:0] to_bcd(input int v);
      return {4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         if (use_gaps && $urandom_range(0, 7) == 0) @(negedge clk);
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
      end
   endtask

   // comparator pulse with ticks halted; first=1 when the reference is still on
   task automatic pulse_cmp(input bit first);
      cmp_below_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      if (first) chk(ref_en_o == 1'b1, "R4", "ref before sync latency", ref_en_o, 1);
      @(negedge clk);
      chk(ref_en_o == 1'b0, first ? "R4" : "R5", "ref after crossing", ref_en_o, 0);
      cmp_below_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_display(input string tag);
      chk(bcd_o == e_bcd, tag, "bcd", bcd_o, e_bcd);
      chk(lead_o[0] == e_lead, tag, "lead", lead_o, e_lead);
      chk(sign_o == e_sign, tag, "sign", sign_o, e_sign);
      chk(over_o == e_over, tag, "over", over_o, e_over);
   endtask

   task automatic expect_reading(input int k, input bit pol);
      if (k >= 0 && k < 2000) begin
         e_bcd  = to_bcd(k % 1000);
         e_lead = (k >= 1000);
         e_sign = pol;
         e_over = 1'b0;
      end else begin
         e_over = 1'b1;
      end
   endtask

   // one frame from count 0; k<0 = no crossing; k2>k adds a second pulse
   task automatic frame(input int k, input int k2, input bit pol, input bit flip);
      int pos = 0;
      pol_neg_i = pol;
      if (k >= 0) begin
         run_ticks(k);
         pos = k;
         pulse_cmp(1'b1);
         if (flip) pol_neg_i = ~pol;
         if (k2 > k) begin
            run_ticks(k2 - k);
            pos = k2;
            pulse_cmp(1'b0);
         end
      end
      run_ticks(FRAME - pos - 1);
      if (k >= 0) chk(ref_en_o == 1'b0, "R2", "ref before last tick", ref_en_o, 0);
      check_display("R6");
      run_ticks(1);
      chk(ref_en_o == 1'b1, "R3", "ref after frame end", ref_en_o, 1);
      expect_reading(k, pol);
      if (k >= 2000 || k < 0) check_display("R9");
      else if (flip) check_display("R8");
      else check_display("R7");
   endtask

   initial begin
      rst = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      chk(ref_en_o == 1'b1, "R1", "reset ref", ref_en_o, 1);
      check_display("R1");

      frame(0, -1, 1'b0, 1'b0);
      frame(999, -1, 1'b1, 1'b0);
      frame(1000, -1, 1'b0, 1'b1);
      frame(1999, -1, 1'b1, 1'b1);
      frame(2000, -1, 1'b0, 1'b0);
      frame(-1, -1, 1'b1, 1'b0);
      frame(5, -1, 1'b1, 1'b0);
      chk(over_o == 1'b0, "R11", "overrange cleared", over_o, 0);
      frame(300, 1500, 1'b0, 1'b0);

      // R10: crossing taken on the same edge as the frame end
      pol_neg_i = 1'b1;
      run_ticks(FRAME - 1);
      cmp_below_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      cmp_below_i = 1'b0;
      chk(ref_en_o == 1'b1, "R10", "ref after shared edge", ref_en_o, 1);
      e_over = 1'b1;
      check_display("R10");
      repeat (4) @(negedge clk);
      chk(ref_en_o == 1'b1, "R10", "no stray capture", ref_en_o, 1);
      frame(1234, -1, 1'b0, 1'b0);

      // constrained random frames with tick gaps
      void'($urandom(32'd4711));
      use_gaps = 1'b1;
      for (int f = 0; f < 12; f++) begin
         int kk;
         kk = ($urandom_range(0, 7) == 0) ? -1 : int'($urandom_range(0, 2600));
         frame(kk, -1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule